// File: doc/BRIEF.md
# Serial Port Register Block

This block is the processor-side register file of an asynchronous serial peripheral. A byte-wide bus with a 2-bit offset reaches four locations: data, status, command and control. Each byte the processor writes to the data location goes out on a transmit byte stream with a valid/ready handshake. Each byte that arrives on the receive byte stream is held for the processor to read back from the data location. Baud timing, bit shifting, parity and framing sit outside this block, on the far side of the two streams.

A status byte reports overrun, receive-full and transmit-empty. Two enable bits in the command register decide which of those conditions raise the interrupt request. The control register holds a byte for the serial engine and has no effect inside this block. A write of any value to the status location clears the whole block back to its reset state. The receive side never stalls the incoming stream. A byte that arrives before the previous one is read replaces it and is recorded as an overrun.

Top module: `serial_regs`

## Requirements
- R1: After reset, or after a soft reset, the data, command and control locations read 0x00, status reads 0x10, tx_valid_o is low and irq_o is low.
- R2: A write with we_i high at offset 0 puts wdata_i on tx_data_o and raises tx_valid_o from the next cycle. It also clears transmit-empty (status bit 4).
- R3: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_data_o hold. The cycle after tx_valid_o and tx_ready_i are both high, tx_valid_o is low and status bit 4 is set.
- R4: A byte accepted on the receive stream (rx_valid_i high, rx_ready_o always high) is returned by a read of offset 0 and sets receive-full (status bit 3).
- R5: When a byte arrives while receive-full is set, the new byte replaces the old one and overrun (status bit 2) is set.
- R6: A read with re_i high at offset 0, in a cycle with no arriving byte, clears receive-full and overrun from the next cycle.
- R7: A status read (offset 1) returns overrun in bit 2, receive-full in bit 3 and transmit-empty in bit 4. Bits 7:5 and 1:0 read zero.
- R8: The command register (offset 2) reads back the last byte written. Bit 1 is the receive interrupt enable and bit 2 is the transmit interrupt enable.
- R9: irq_o equals (command bit 1 AND receive-full) OR (command bit 2 AND transmit-empty).
- R10: The control register (offset 3) reads back any byte written (0xB8 reads 0xB8). Its value changes no other output.
- R11: A write of any value to offset 1 performs the soft reset of R1 at that clock edge. Any byte in transmission and any held received byte are discarded.
- R12: Register writes take effect only at a clock edge with we_i high. With we_i low, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (side effects at offset 0) |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| tx_data_o | output | 8 | Transmit stream byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit sink ready |
| rx_data_i | input | 8 | Receive stream byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_ready_o | output | 1 | Receive ready (always high) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume we_i and re_i are never high in the same cycle. They also assume that a read clears the receive flags only when no byte arrives in that cycle, since an arriving byte takes priority. The bench drives each bus access as a single-cycle strobe on the falling edge and never overlaps a read with a write. Its receive pushes and transmit ready pulses are each one cycle wide and are placed between bus accesses. The one exception is the deliberate same-cycle case of a write and a transmit accept, where the write wins.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    OFF_DATA = 2'd0,
    OFF_STAT = 2'd1,
    OFF_CMD  = 2'd2,
    OFF_CTRL = 2'd3
  } off_e;

  localparam int ST_OVR   = 2;
  localparam int ST_RXF   = 3;
  localparam int ST_TXE   = 4;
  localparam int CMD_RXIE = 1;
  localparam int CMD_TXIE = 2;
endpackage

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int DW = sreg_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          empty_o
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (srst_i) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_i) begin
      data_q  <= wdata_i;
      empty_q <= 1'b0;
    end else if (!empty_q && ready_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign valid_o = !empty_q;
  assign empty_o = empty_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !srst_i) |=> (valid_o && data_o == $past(wdata_i)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !wr_i && !srst_i) |=> (valid_o && $stable(data_o)));
  a_r3_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !wr_i && !srst_i) |=> (!valid_o && empty_o));
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx #(
  parameter int DW = sreg_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          rd_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          ready_o,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o
);
  logic [DW-1:0] data_q;
  logic          full_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (srst_i) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (valid_i) begin
      // arrival wins over a same-cycle read; that read consumed the old byte
      data_q <= data_i;
      full_q <= 1'b1;
      ovr_q  <= full_q && !rd_i ? 1'b1 : (rd_i ? 1'b0 : ovr_q);
    end else if (rd_i) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign ready_o = 1'b1;
  assign data_o  = data_q;
  assign full_o  = full_q;
  assign ovr_o   = ovr_q;

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !srst_i) |=> (full_o && data_o == $past(data_i)));
  a_r5_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_o && !rd_i && !srst_i) |=> ovr_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !valid_i) |=> (!full_o && !ovr_o));
  a_r5_ovr_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> full_o);
endmodule

// File: rtl/sreg_cfg.sv
module sreg_cfg #(
  parameter int DW = sreg_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          cmd_wr_i,
  input  logic          ctrl_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rx_full_i,
  input  logic          tx_empty_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_o
);
  import sreg_pkg::*;
  logic [DW-1:0] cmd_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else if (srst_i) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cmd_wr_i)  cmd_q  <= wdata_i;
      if (ctrl_wr_i) ctrl_q <= wdata_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = (cmd_q[CMD_RXIE] & rx_full_i) | (cmd_q[CMD_TXIE] & tx_empty_i);

  a_r8_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wr_i && !srst_i) |=> $stable(cmd_o));
  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && !srst_i) |=> $stable(ctrl_o));
endmodule

// File: rtl/serial_regs.sv
module serial_regs #(
  parameter int DW = sreg_pkg::DW,
  parameter int AW = sreg_pkg::AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  output logic          irq_o
);
  import sreg_pkg::*;

  logic          srst, data_wr, data_rd, cmd_wr, ctrl_wr;
  logic          tx_empty, rx_full, rx_ovr;
  logic [DW-1:0] rx_data, cmd_q, ctrl_q, status;

  assign srst    = we_i && (addr_i == OFF_STAT);
  assign data_wr = we_i && (addr_i == OFF_DATA);
  assign data_rd = re_i && (addr_i == OFF_DATA);
  assign cmd_wr  = we_i && (addr_i == OFF_CMD);
  assign ctrl_wr = we_i && (addr_i == OFF_CTRL);

  sreg_tx #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .srst_i(srst), .wr_i(data_wr), .wdata_i,
    .ready_i(tx_ready_i), .data_o(tx_data_o), .valid_o(tx_valid_o), .empty_o(tx_empty)
  );

  sreg_rx #(.DW(DW)) u_rx (
    .clk_i, .rst_ni, .srst_i(srst), .rd_i(data_rd), .valid_i(rx_valid_i),
    .data_i(rx_data_i), .ready_o(rx_ready_o), .data_o(rx_data), .full_o(rx_full), .ovr_o(rx_ovr)
  );

  sreg_cfg #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni, .srst_i(srst), .cmd_wr_i(cmd_wr), .ctrl_wr_i(ctrl_wr), .wdata_i,
    .rx_full_i(rx_full), .tx_empty_i(tx_empty), .cmd_o(cmd_q), .ctrl_o(ctrl_q), .irq_o
  );

  always_comb begin
    status         = '0;
    status[ST_OVR] = rx_ovr;
    status[ST_RXF] = rx_full;
    status[ST_TXE] = tx_empty;
  end

  always_comb begin
    unique case (addr_i)
      OFF_DATA: rdata_o = rx_data;
      OFF_STAT: rdata_o = status;
      OFF_CMD:  rdata_o = cmd_q;
      default:  rdata_o = ctrl_q;
    endcase
  end

  a_r11_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (!tx_valid_o && !irq_o));
  a_r7_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_STAT) |-> (rdata_o[7:5] == 3'b0 && rdata_o[1:0] == 2'b0));
  a_r12_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_full && !tx_empty) |-> !irq_o);
endmodule

// File: tb/serial_regs_bench.sv
module serial_regs_bench;
  localparam int CLK_PERIOD = 10;
  // entry: {op(1: 0 write, 1 read-check), addr(2), wdata(8), expected(8)}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd1, 8'h00, 8'h10},  // R7 idle status
    {1'b0, 2'd3, 8'hB8, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'hB8},  // R10
    {1'b0, 2'd2, 8'h02, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h02},  // R8
    {1'b0, 2'd2, 8'h04, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h04},
    {1'b0, 2'd2, 8'h06, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h06},
    {1'b0, 2'd3, 8'h5A, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'h5A},
    {1'b1, 2'd2, 8'h00, 8'h06}   // R12 cmd kept over ctrl write
  };

  logic clk = 0, rst_ni = 0;
  logic we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, tx_data, rx_data = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_regs u_serial_regs (
    .clk_i(clk), .rst_ni, .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk); re = 1; addr = a; #1;
    chk(req, rdata, exp);
    @(negedge clk); re = 0;
  endtask

  // look without side effect: offset 0 read strobe low
  task automatic peek(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    peek(2'd0, "R1 data", 8'h00);
    peek(2'd1, "R1 status", 8'h10);
    peek(2'd2, "R1 cmd", 8'h00);
    peek(2'd3, "R1 ctrl", 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R4 rx_ready", {7'b0, rx_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) rd(VEC[i][17:16], "R7/R8/R10/R12 vec", VEC[i][7:0]);
      else wr(VEC[i][17:16], VEC[i][15:8]);
    end
    wr(2'd2, 8'h00);

    // R2/R3 transmit
    wr(2'd0, 8'h42);
    chk("R2 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R2 tx_data", tx_data, 8'h42);
    peek(2'd1, "R2 status txe clear", 8'h00);
    repeat (3) @(negedge clk);
    chk("R3 hold valid", {7'b0, tx_valid}, 8'h01);
    chk("R3 hold data", tx_data, 8'h42);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R3 valid drop", {7'b0, tx_valid}, 8'h00);
    peek(2'd1, "R3 status txe", 8'h10);

    // write wins over same-cycle accept
    wr(2'd0, 8'h11);
    @(negedge clk); tx_ready = 1; we = 1; addr = 2'd0; wdata = 8'h22;
    @(negedge clk); tx_ready = 0; we = 0;
    chk("R2 write beats accept", {tx_valid, tx_data[6:0]}, 8'hA2);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;

    // R4/R5/R6 receive
    push(8'hAB);
    peek(2'd1, "R4 status rxf", 8'h18);
    rd(2'd0, "R4 data", 8'hAB);
    peek(2'd1, "R6 status clear", 8'h10);
    push(8'h42); push(8'h32); push(8'hAB);
    peek(2'd1, "R5 status ovr", 8'h1C);
    rd(2'd0, "R5 last byte", 8'hAB);
    peek(2'd1, "R6 ovr clear", 8'h10);

    // R9 interrupts
    wr(2'd2, 8'h02);
    chk("R9 rx ie idle", {7'b0, irq}, 8'h00);
    push(8'h07);
    chk("R9 rx irq", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'hFF);
    chk("R10 ctrl no effect", {7'b0, irq}, 8'h01);
    rd(2'd0, "R9 rx byte", 8'h07);
    chk("R9 rx irq clear", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h04);
    chk("R9 tx irq", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h55);
    chk("R9 tx irq clear", {7'b0, irq}, 8'h00);

    // R11 soft reset while busy
    wr(2'd2, 8'h06);
    push(8'h99);
    wr(2'd1, 8'hA5);
    chk("R11 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    peek(2'd0, "R11 data", 8'h00);
    peek(2'd1, "R11 status", 8'h10);
    peek(2'd2, "R11 cmd", 8'h00);
    peek(2'd3, "R11 ctrl", 8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule